// File: doc/BRIEF.md
# Address Table Violation Capture Unit

The unit sits beside an address table and holds on to the first problem the table reports. The table raises four kinds of problem: an entry aged out, a port that is not a member, a lookup miss, and a full table. Each report is a one-cycle pulse. It carries a kind vector, the offending MAC address, the source port number and a port vector. The first report is latched. The unit then raises a single interrupt line and ignores later reports, apart from noting in a sticky overflow bit that one was lost.

Software collects the event by writing a get-and-clear command into the operation register with the start bit set. The command engine has two states. In `ST_IDLE` it waits for a command write with the start bit at 1, which is the IDLE->EXEC transition. In `ST_EXEC`, which always lasts one cycle, the start bit reads back as busy. On leaving `ST_EXEC` (the EXEC->IDLE transition) a get-and-clear copies the capture into the readable registers. The kind flags and the overflow bit go to the operation register. The source port goes to the low nibble of the data register, the port vector sits just above it, and the MAC address goes to three 16-bit MAC words. The same transition empties the capture and drops the interrupt. Any other opcode passes through `ST_EXEC` without touching the capture.

Top module: `viol_capture`

## Requirements
- R1: After reset, `irq` is 0 and every readable register (addresses 0 to 4) reads 0.
- R2: An `evt_valid` pulse while nothing is pending sets `irq` to 1 from the next clock edge.
- R3: A command write with `cmd_wdata[3]`=1 starts a command whose opcode is `cmd_wdata[2:0]`. The operation register (address 0) then reads bit 15 (busy) as 1 for exactly one cycle, with bits [14:12] holding the opcode. Opcode 3'b111 is get-and-clear.
- R4: After get-and-clear, operation register bits [7:4] hold the captured `evt_kind` (bit 4 age-out, 5 member, 6 miss, 7 full). Data register (address 1) bits [3:0] hold the source port and bits [4+PORTS-1:4] hold the port vector. All other bits are 0.
- R5: After get-and-clear, the MAC words at addresses 2, 3 and 4 hold MAC bytes {0,1}, {2,3} and {4,5}, with the lower-numbered byte in bits [15:8]. Byte 0 is `evt_mac[47:40]`.
- R6: `irq` is 0 from the clock edge on which get-and-clear completes, unless an event arrives in that same cycle.
- R7: While an event is pending, further events are dropped and the captured values are kept. A sticky overflow flag is set and reads as operation register bit 8 after the next get-and-clear, which also clears it.
- R8: Get-and-clear with nothing pending returns flags 0, overflow 0, a data register of 0 and MAC words of 0.
- R9: A command with any opcode other than 3'b111 completes in one cycle. It leaves `irq`, the data register and the MAC words unchanged.
- R10: A command write in the cycle busy reads 1 is ignored. The opcode field keeps the first command's value, and no second command runs.
- R11: An event that arrives in the cycle in which get-and-clear completes becomes the new pending capture. It is absent from that readout, and `irq` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | One-cycle violation report pulse |
| evt_kind | input | 4 | Violation kinds: [0] age-out, [1] member, [2] miss, [3] full |
| evt_mac | input | 48 | Offending MAC address, byte 0 in [47:40] |
| evt_spid | input | 4 | Source port number |
| evt_pvec | input | PORTS | Port vector of the report |
| cmd_wr | input | 1 | Write strobe for the operation register |
| cmd_wdata | input | 4 | Command: [3] start, [2:0] opcode |
| reg_addr | input | 3 | Read address: 0 operation, 1 data, 2..4 MAC words |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Violation pending interrupt |

## Verification
The bench checks the collision cases:
- **Event in the completing cycle.** An event lands exactly in the cycle a get-and-clear completes. A design that clears after latching would lose that event and drop `irq`.
- **Second event while one is pending.** A design that overwrites instead of dropping would return the second MAC, and one without the sticky bit would report no overflow.
- **Back-to-back command writes.** A command written while busy reads 1 must not restart the engine. Accepting it would show the wrong opcode or keep busy set for a further cycle.
- **Empty get-and-clear and other opcodes.** Get-and-clear on an empty capture must return all zeros. A non-clearing opcode must leave the interrupt and the readout alone, which catches a decoder that clears on any command.

// File: rtl/vcap_pkg.sv
package vcap_pkg;
    typedef enum logic [0:0] {ST_IDLE, ST_EXEC} cmd_state_t;

    localparam logic [2:0] OPC_GETCLR = 3'b111;

    localparam int REG_W   = 16;
    localparam int ADDR_W  = 3;
    localparam int KIND_W  = 4;
    localparam int SPID_W  = 4;
    localparam int MAC_W   = 48;
    localparam int MAC_WORDS = MAC_W / REG_W;

    localparam logic [ADDR_W-1:0] ADR_OP   = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_DATA = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_MAC0 = 3'd2;
endpackage

// File: rtl/vcap_latch.sv
module vcap_latch
    import vcap_pkg::*;
#(
    parameter int PORTS = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                evt_valid,
    input  logic [KIND_W-1:0]   evt_kind,
    input  logic [MAC_W-1:0]    evt_mac,
    input  logic [SPID_W-1:0]   evt_spid,
    input  logic [PORTS-1:0]    evt_pvec,
    input  logic                clear,
    output logic                pending,
    output logic                ovf,
    output logic [KIND_W-1:0]   cap_kind,
    output logic [MAC_W-1:0]    cap_mac,
    output logic [SPID_W-1:0]   cap_spid,
    output logic [PORTS-1:0]    cap_pvec
);
    logic take;

    always_comb take = evt_valid && (clear || !pending);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending  <= 1'b0;
            ovf      <= 1'b0;
            cap_kind <= '0;
            cap_mac  <= '0;
            cap_spid <= '0;
            cap_pvec <= '0;
        end else begin
            if (clear) begin
                pending  <= 1'b0;
                ovf      <= 1'b0;
                cap_kind <= '0;
                cap_mac  <= '0;
                cap_spid <= '0;
                cap_pvec <= '0;
            end else if (evt_valid && pending) begin
                ovf <= 1'b1;
            end
            if (take) begin
                pending  <= 1'b1;
                cap_kind <= evt_kind;
                cap_mac  <= evt_mac;
                cap_spid <= evt_spid;
                cap_pvec <= evt_pvec;
            end
        end
    end

    AST_IRQ_ON_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !pending) |=> pending); // R2
    AST_KEEP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && pending && !clear) |=> ($stable(cap_mac) && ovf)); // R7
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !evt_valid) |=> (!pending && !ovf)); // R6
    AST_RACE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && evt_valid) |=> pending); // R11
endmodule

// File: rtl/vcap_cmd_fsm.sv
module vcap_cmd_fsm
    import vcap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [3:0] cmd_wdata,
    output logic       busy,
    output logic       clear,
    output logic [2:0] last_opc
);
    cmd_state_t state, state_nx;
    logic       accept;

    always_comb accept = cmd_wr && cmd_wdata[3] && (state == ST_IDLE);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) state_nx = ST_EXEC;
            ST_EXEC: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            last_opc <= '0;
        end else begin
            state <= state_nx;
            if (accept) last_opc <= cmd_wdata[2:0];
        end
    end

    always_comb begin
        busy  = 1'b0;
        clear = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_EXEC: begin
                busy  = 1'b1;
                clear = (last_opc == OPC_GETCLR);
            end
        endcase
    end

    AST_ONE_CYCLE_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC) |=> (state == ST_IDLE)); // R3
    AST_BUSY_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && cmd_wr) |=> $stable(last_opc)); // R10
endmodule

// File: rtl/vcap_readout.sv
module vcap_readout
    import vcap_pkg::*;
#(
    parameter int PORTS = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [KIND_W-1:0]   cap_kind,
    input  logic                cap_ovf,
    input  logic [MAC_W-1:0]    cap_mac,
    input  logic [SPID_W-1:0]   cap_spid,
    input  logic [PORTS-1:0]    cap_pvec,
    output logic [KIND_W-1:0]   ro_kind,
    output logic                ro_ovf,
    output logic [REG_W-1:0]    ro_data,
    output logic [MAC_W-1:0]    ro_mac
);
    localparam int PAD_W = REG_W - SPID_W - PORTS;

    logic [REG_W-1:0] data_nx;

    generate
        if (PAD_W > 0) begin : g_pad
            always_comb data_nx = {{PAD_W{1'b0}}, cap_pvec, cap_spid};
        end else begin : g_nopad
            always_comb data_nx = {cap_pvec, cap_spid};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ro_kind <= '0;
            ro_ovf  <= 1'b0;
            ro_data <= '0;
            ro_mac  <= '0;
        end else if (load) begin
            ro_kind <= cap_kind;
            ro_ovf  <= cap_ovf;
            ro_data <= data_nx;
            ro_mac  <= cap_mac;
        end
    end

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(ro_data) && $stable(ro_mac))); // R9
endmodule

// File: rtl/viol_capture.sv
module viol_capture
    import vcap_pkg::*;
#(
    parameter int PORTS = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                evt_valid,
    input  logic [3:0]          evt_kind,
    input  logic [47:0]         evt_mac,
    input  logic [3:0]          evt_spid,
    input  logic [PORTS-1:0]    evt_pvec,
    input  logic                cmd_wr,
    input  logic [3:0]          cmd_wdata,
    input  logic [2:0]          reg_addr,
    output logic [15:0]         reg_rdata,
    output logic                irq
);
    logic                busy, clear, pending, cap_ovf, ro_ovf;
    logic [2:0]          last_opc;
    logic [KIND_W-1:0]   cap_kind, ro_kind;
    logic [MAC_W-1:0]    cap_mac, ro_mac;
    logic [SPID_W-1:0]   cap_spid;
    logic [PORTS-1:0]    cap_pvec;
    logic [REG_W-1:0]    ro_data;
    logic [REG_W-1:0]    op_word;
    logic [REG_W-1:0]    mac_word [MAC_WORDS];

    vcap_cmd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .busy(busy), .clear(clear), .last_opc(last_opc)
    );

    vcap_latch #(.PORTS(PORTS)) u_latch (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_kind(evt_kind),
        .evt_mac(evt_mac), .evt_spid(evt_spid), .evt_pvec(evt_pvec),
        .clear(clear), .pending(pending), .ovf(cap_ovf), .cap_kind(cap_kind),
        .cap_mac(cap_mac), .cap_spid(cap_spid), .cap_pvec(cap_pvec)
    );

    vcap_readout #(.PORTS(PORTS)) u_ro (
        .clk(clk), .rst_n(rst_n), .load(clear), .cap_kind(cap_kind),
        .cap_ovf(cap_ovf), .cap_mac(cap_mac), .cap_spid(cap_spid),
        .cap_pvec(cap_pvec), .ro_kind(ro_kind), .ro_ovf(ro_ovf),
        .ro_data(ro_data), .ro_mac(ro_mac)
    );

    genvar gi;
    generate
        for (gi = 0; gi < MAC_WORDS; gi++) begin : g_macw
            always_comb mac_word[gi] = ro_mac[MAC_W-1-gi*REG_W -: REG_W];
        end
    endgenerate

    always_comb op_word = {busy, last_opc, 3'b000, ro_ovf, ro_kind, 4'b0000};
    always_comb irq = pending;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADR_OP)        reg_rdata = op_word;
        else if (reg_addr == ADR_DATA) reg_rdata = ro_data;
        else begin
            for (int k = 0; k < MAC_WORDS; k++)
                if (reg_addr == ADR_MAC0 + ADDR_W'(k)) reg_rdata = mac_word[k];
        end
    end

    AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !evt_valid) |=> !irq); // R6
endmodule

// File: tb/sim_viol_capture.sv
module sim_viol_capture;
    localparam int PORTS = 11;

    logic clk = 0, rst_n = 0;
    logic evt_valid = 0;
    logic [3:0] evt_kind = 0;
    logic [47:0] evt_mac = 0;
    logic [3:0] evt_spid = 0;
    logic [PORTS-1:0] evt_pvec = 0;
    logic cmd_wr = 0;
    logic [3:0] cmd_wdata = 0;
    logic [2:0] reg_addr = 0;
    logic [15:0] reg_rdata;
    logic irq;

    int checks = 0, errors = 0;
    bit done = 0;

    viol_capture #(.PORTS(PORTS)) u0 (.*);

    always #10 clk = ~clk;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        reg_addr = a; #1; v = reg_rdata;
    endtask

    task automatic pulse_evt(logic [3:0] k, logic [47:0] m, logic [3:0] s, logic [PORTS-1:0] p);
        @(negedge clk);
        evt_valid = 1; evt_kind = k; evt_mac = m; evt_spid = s; evt_pvec = p;
        @(negedge clk);
        evt_valid = 0;
    endtask

    task automatic issue(logic [2:0] opc);
        @(negedge clk);
        cmd_wr = 1; cmd_wdata = {1'b1, opc};
        @(negedge clk);
        cmd_wr = 0;
    endtask

    function automatic logic [15:0] exp_op(logic [2:0] opc, logic ov, logic [3:0] k);
        return {1'b0, opc, 3'b000, ov, k, 4'b0000};
    endfunction

    task automatic check_readout(string req, logic [2:0] opc, logic ov, logic [3:0] k,
                                 logic [47:0] m, logic [3:0] s, logic [PORTS-1:0] p);
        logic [15:0] v;
        rd(3'd0, v); check({req, " op"}, v, exp_op(opc, ov, k));
        rd(3'd1, v); check({req, " data"}, v, {1'b0, p, s});
        rd(3'd2, v); check({req, " mac0"}, v, m[47:32]);
        rd(3'd3, v); check({req, " mac1"}, v, m[31:16]);
        rd(3'd4, v); check({req, " mac2"}, v, m[15:0]);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        check("R1 irq", irq, 0);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v); check("R1 reg", v, 0);
        end
    endtask

    task automatic t_single;
        logic [15:0] v;
        pulse_evt(4'b0010, 48'hA1B2C3D4E5F6, 4'h9, 11'h5A3);
        check("R2 irq set", irq, 1);
        issue(3'b111);
        rd(3'd0, v); check("R3 busy", v[15:12], 4'hF);
        @(negedge clk);
        rd(3'd0, v); check("R3 busy clear", v[15], 0);
        check("R6 irq clear", irq, 0);
        check_readout("R4 R5 readout", 3'b111, 0, 4'b0010, 48'hA1B2C3D4E5F6, 4'h9, 11'h5A3);
    endtask

    task automatic t_overflow;
        pulse_evt(4'b1000, 48'h010203040506, 4'h3, 11'h011);
        pulse_evt(4'b0001, 48'hFFEEDDCCBBAA, 4'hC, 11'h7FF);
        check("R7 irq", irq, 1);
        issue(3'b111); @(negedge clk);
        check_readout("R7 first kept", 3'b111, 1, 4'b1000, 48'h010203040506, 4'h3, 11'h011);
        issue(3'b111); @(negedge clk);
        check_readout("R8 empty ovf cleared", 3'b111, 0, 4'b0000, 48'h0, 4'h0, 11'h0);
    endtask

    task automatic t_other_op;
        logic [15:0] v;
        pulse_evt(4'b0100, 48'h123456789ABC, 4'h5, 11'h222);
        issue(3'b010);
        @(negedge clk);
        check("R9 irq kept", irq, 1);
        rd(3'd0, v); check("R9 op", v, exp_op(3'b010, 0, 0));
        rd(3'd1, v); check("R9 data", v, 0);
        rd(3'd2, v); check("R9 mac0", v, 0);
        issue(3'b111); @(negedge clk);
        check_readout("R9 later clear", 3'b111, 0, 4'b0100, 48'h123456789ABC, 4'h5, 11'h222);
    endtask

    task automatic t_busy_write;
        logic [15:0] v;
        issue(3'b111);
        cmd_wr = 1; cmd_wdata = 4'b1001;
        @(negedge clk);
        cmd_wr = 0;
        rd(3'd0, v);
        check("R10 opcode kept", v[14:12], 3'b111);
        check("R10 no restart", v[15], 0);
    endtask

    task automatic t_race;
        logic [15:0] v;
        pulse_evt(4'b0011, 48'hAABBCCDDEEFF, 4'h1, 11'h001);
        issue(3'b111);
        evt_valid = 1; evt_kind = 4'b0100; evt_mac = 48'h112233445566;
        evt_spid = 4'h7; evt_pvec = 11'h400;
        @(negedge clk);
        evt_valid = 0;
        check("R11 irq held", irq, 1);
        check_readout("R11 old out", 3'b111, 0, 4'b0011, 48'hAABBCCDDEEFF, 4'h1, 11'h001);
        issue(3'b111); @(negedge clk);
        check_readout("R11 new out", 3'b111, 0, 4'b0100, 48'h112233445566, 4'h7, 11'h400);
        check("R6 irq after", irq, 0);
    endtask

    initial begin
        #1;
        t_reset;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_single;
        t_overflow;
        t_other_op;
        t_busy_write;
        t_race;
        done = 1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule